// File: doc/BRIEF.md
# Cellular Gray Up/Down Counter

This block is an N-bit reflected Gray code counter that steps one code forward or one code back on each clock edge where it is enabled. Every output bit comes straight from a flip-flop. The output therefore never glitches through a non-Gray value, and it can serve as a pointer that another clock domain samples.

The counter does not convert to binary and does not use a next-state table. It is a chain of identical bit cells. Each cell holds one toggle flip-flop and decides only whether its bit flips on the next edge. That decision uses three inputs: the bit just below it, a flag that is chained from cell to cell and says all bits further down are zero, and the parity of the whole word. The parity comes from a register that flips on every count, or from an XOR reduction of the outputs. A parameter selects which form is used, and both forms give the same sequence.

Top module: `gray_updown_ctr`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released with the enable low, every bit of the Gray output is 0.
- R2: When the enable is low, the output keeps its value across the clock edge, whatever the direction input is.
- R3: When enabled with the direction input at 1 (up), the output moves to the next code of the reflected Gray sequence. Example for 3 bits: 000, 001, 011, 010, 110, 111, 101, 100. The step after 111 is 101.
- R4: When enabled with the direction input at 0 (down), the output moves to the previous code of the same sequence.
- R5: Each enabled step changes exactly one output bit. A held cycle changes none.
- R6: Counting up from the code that has only the top bit set (the last code) wraps to all zeros.
- R7: Counting down from all zeros wraps to the code that has only the top bit set.
- R8: A change of direction takes effect on the very step where it is applied. No idle cycle is needed.
- R9: The parity-register variant and the XOR-reduction variant produce identical output sequences for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| gray_o | output | N | Registered Gray code value |

## Verification
In a single cycle, a change of direction can coincide with a wrap through the ends of the sequence. The parity sense of the lowest cell then flips at the same moment that the top cell meets its all-zero condition. The stimulus sweeps widths 2, 3, 5 and 8 fully up and fully down. It then applies random direction changes with random enable gaps, so direction flips land on the all-zero and top-only codes. Each step is scored against a model that converts Gray to binary, adds or subtracts one and converts back, and the two parity variants are compared with each other every cycle.

// File: rtl/gray_ctr_pkg.sv
package gray_ctr_pkg;

    typedef enum logic [0:0] {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

endpackage

// File: rtl/gray_ctr_parity.sv
module gray_ctr_parity #(
    parameter int N             = 4,
    parameter bit PAR_FROM_FLOP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [N-1:0] q_i,
    output logic         par_o
);

    if (PAR_FROM_FLOP) begin : g_flop
        logic par_q;
        logic unused_q;

        // All-zero reset word has even parity; each step flips it.
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                par_q <= 1'b0;
            end else if (en_i) begin
                par_q <= ~par_q;
            end
        end

        assign par_o    = par_q;
        assign unused_q = ^q_i;
    end else begin : g_xor
        logic unused_ctl;

        assign par_o      = ^q_i;
        assign unused_ctl = clk ^ rst ^ en_i;
    end

endmodule

// File: rtl/gray_ctr_cell.sv
module gray_ctr_cell
    import gray_ctr_pkg::*;
#(
    parameter bit LSB_CELL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  dir_e dir_i,
    input  logic par_i,
    input  logic q_low_i,
    input  logic z_low_i,
    output logic q_o,
    output logic z_o
);

    logic par_ok;
    logic flip;

    // The lowest cell reacts to the opposite parity sense from the others.
    always_comb begin
        unique case (dir_i)
            DIR_UP:   par_ok = LSB_CELL ? ~par_i : par_i;
            DIR_DOWN: par_ok = LSB_CELL ? par_i : ~par_i;
        endcase
    end

    assign flip = en_i & q_low_i & z_low_i & par_ok;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q_o <= 1'b0;
        end else if (flip) begin
            q_o <= ~q_o;
        end
    end

    assign z_o = z_low_i & ~q_low_i;

endmodule

// File: rtl/gray_updown_ctr.sv
module gray_updown_ctr
    import gray_ctr_pkg::*;
#(
    parameter int N             = 4,
    parameter bit PAR_FROM_FLOP = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         up_i,
    output logic [N-1:0] gray_o
);

    localparam int MSB = N - 1;

    dir_e         dir;
    logic         par_w;
    logic [N-1:0] q;
    logic [N-1:0] zc;
    logic         unused_zc;

    assign dir = up_i ? DIR_UP : DIR_DOWN;

    gray_ctr_parity #(
        .N             (N),
        .PAR_FROM_FLOP (PAR_FROM_FLOP)
    ) u_par (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en_i),
        .q_i   (q),
        .par_o (par_w)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic q_low;
        logic z_low;

        if (i == 0) begin : g_edge0
            assign q_low = 1'b1;
            assign z_low = 1'b1;
        end else if (i == MSB) begin : g_top
            assign q_low = 1'b1;
            assign z_low = (i == 1) ? 1'b1 : zc[i-1];
        end else if (i == 1) begin : g_edge1
            assign q_low = q[0];
            assign z_low = 1'b1;
        end else begin : g_mid
            assign q_low = q[i-1];
            assign z_low = zc[i-1];
        end

        gray_ctr_cell #(
            .LSB_CELL (i == 0)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .en_i    (en_i),
            .dir_i   (dir),
            .par_i   (par_w),
            .q_low_i (q_low),
            .z_low_i (z_low),
            .q_o     (q[i]),
            .z_o     (zc[i])
        );
    end

    assign unused_zc = zc[0] & zc[MSB];
    assign gray_o    = q;

endmodule

// File: rtl/gray_updown_ctr_chk.sv
module gray_updown_ctr_chk #(
    parameter int N             = 4,
    parameter bit PAR_FROM_FLOP = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         en_i,
    input logic         up_i,
    input logic [N-1:0] gray_o,
    input logic         par
);

    localparam logic [N-1:0] TOP_ONLY = {1'b1, {(N-1){1'b0}}};

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(gray_o));

    assert_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
        en_i |=> $countones(gray_o ^ $past(gray_o)) == 1);

    assert_wrap_up_R6: assert property (@(posedge clk) disable iff (rst)
        (en_i && up_i && gray_o == TOP_ONLY) |=> gray_o == '0);

    assert_wrap_down_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && !up_i && gray_o == '0) |=> gray_o == TOP_ONLY);

    if (PAR_FROM_FLOP) begin : g_par_chk
        assert_parity_track_R9: assert property (@(posedge clk) disable iff (rst)
            par == ^gray_o);
    end

endmodule

bind gray_updown_ctr gray_updown_ctr_chk #(
    .N             (N),
    .PAR_FROM_FLOP (PAR_FROM_FLOP)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .up_i   (up_i),
    .gray_o (gray_o),
    .par    (par_w)
);

// File: tb/gray_updown_ctr_test.sv
`timescale 1ns/1ps
module gray_updown_ctr_test;

    localparam int NI = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic up  = 1'b0;
    always #10 clk = ~clk;

    logic [7:0] outs [NI];

    for (genvar k = 0; k < 4; k++) begin : gen_w
        localparam int W = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 5 : 8;
        for (genvar m = 0; m < 2; m++) begin : gen_m
            logic [W-1:0] g;
            gray_updown_ctr #(.N(W), .PAR_FROM_FLOP(m == 0)) uut (
                .clk    (clk),
                .rst    (rst),
                .en_i   (en),
                .up_i   (up),
                .gray_o (g)
            );
            assign outs[k*2+m] = 8'(g);
        end
    end

    typedef struct packed {
        logic                en;
        logic                up;
        logic                dirchg;
        logic [NI-1:0][7:0]  prev;
        logic [NI-1:0][7:0]  exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    mb [4];
    logic  last_up = 1'b1;
    bit    finished = 1'b0;

    function automatic int width_of(int k);
        return (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 5 : 8;
    endfunction

    function automatic logic [7:0] b2g(int b);
        logic [7:0] x;
        x = 8'(b);
        return x ^ (x >> 1);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: applies stimulus and pushes the value expected after the edge.
    task automatic step(input logic e, input logic u);
        item_t it;
        @(negedge clk);
        en = e;
        up = u;
        it.en     = e;
        it.up     = u;
        it.dirchg = e && (u != last_up);
        if (e) last_up = u;
        for (int i = 0; i < NI; i++) it.prev[i] = b2g(mb[i/2]);
        for (int k = 0; k < 4; k++) begin
            int mask;
            mask = (1 << width_of(k)) - 1;
            if (e) mb[k] = (u ? mb[k] + 1 : mb[k] - 1) & mask;
        end
        for (int i = 0; i < NI; i++) it.exp[i] = b2g(mb[i/2]);
        q.push_back(it);
    endtask

    // Monitor: pops and scores each step shortly after the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                for (int i = 0; i < NI; i++) begin
                    logic [7:0] top;
                    string tag;
                    top = 8'(1 << (width_of(i/2) - 1));
                    if (!it.en)             tag = "R2";
                    else if (it.dirchg)     tag = "R8";
                    else if (it.up)         tag = (it.prev[i] == top) ? "R6" : "R3";
                    else                    tag = (it.prev[i] == 8'd0) ? "R7" : "R4";
                    check(outs[i] == it.exp[i], tag, outs[i], it.exp[i]);
                    check($countones(outs[i] ^ it.prev[i]) == (it.en ? 1 : 0),
                          "R5", outs[i] ^ it.prev[i], it.exp[i] ^ it.prev[i]);
                    if (i % 2 == 0)
                        check(outs[i] == outs[i+1], "R9", outs[i+1], outs[i]);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) mb[k] = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NI; i++) check(outs[i] == 8'd0, "R1", outs[i], 8'd0);
        rst = 1'b0;
        // First edge after release with enable low: still zero (R1).
        @(posedge clk);
        #2;
        for (int i = 0; i < NI; i++) check(outs[i] == 8'd0, "R1", outs[i], 8'd0);
        // Full sweeps up and down cover R3, R4, R6, R7 at every width.
        for (int n = 0; n < 300; n++) step(1'b1, 1'b1);
        for (int n = 0; n < 40; n++)  step(1'b0, n[0]);
        for (int n = 0; n < 300; n++) step(1'b1, 1'b0);
        // Direction flips at the wrap points (R8 with R6/R7).
        for (int n = 0; n < 20; n++)  step(1'b1, n[0]);
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 8;
            step(r != 0, ($urandom % 3) != 0 ? last_up : ~last_up);
        end
        step(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule